// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-facing control store of an audio codec. The host sees four byte-wide direct ports: an index pointer, a data window, a status port and a programmed-I/O data port. Through the data window it reaches a bank of 8-bit indirect control registers. That bank shows 16 entries in the basic mode and 32 entries in the extended mode. Each indirect register has its own reset value and its own write rule. Some registers take the whole byte. Others take it only while the mode-change-enable flag is set, take only the upper nibble, take a single bit, or take nothing at all.

The block also answers calibration polls from host drivers. When mode-change-enable rises, a short counter is loaded. While that counter is nonzero, reads of the error/initialization register report calibration in progress. The block clears interrupt status for the playback engine. That engine raises interrupts through `play_irq`, and the block returns a one-cycle `irq_clr` strobe whenever software acknowledges an interrupt. The decoded configuration bytes leave the block as plain outputs.

Top module: `codec_regfile`

## Requirements
- R1: After a synchronous active-low reset the index port reads 0x40. The indirect registers read as follows: 2 to 5 read 0x88, 6 and 7 read 0x80, 9 reads 0x08, 12 reads 0x8A, 18 and 19 read 0x88, 25 and 26 read 0xA0, and all the others read 0x00. The status port reads 0x00.
- R2: A write to direct port 0 stores bits 6:0 as the index pointer. Bit 7 is not stored and reads back as 0. Bit 6 is mode-change-enable, and the `mce` output shows it.
- R3: When bit 6 of indirect register 12 is clear, only index bits 3:0 select a register. When that bit is set, index bits 4:0 select one of 32 registers. Port 1 reads and writes the selected register.
- R4: A write to register 12 changes only its bit 6. The `mode_ext` output mirrors that bit.
- R5: Writes to registers 21, 27 and 29 are discarded. Register 11 is read-only, so writes to it are discarded too.
- R6: A write to register 9 stores the written byte with bit 5 forced to 0. The `cfg_iface` output shows register 9.
- R7: A write to register 8 is handled in one of three ways, and `cfg_format` shows the result:
  - When `mce` is 1, the whole byte is stored.
  - When `mce` is 0 and bit 4 of register 24 is 1, only bits 7:4 are stored and bits 3:0 keep their old value.
  - Otherwise the write is dropped.
- R8: A port-0 write can load the calibration counter with CAL_PRESET (default 1). This happens when the stored bit 6 is 0, the written bit 6 is 1, and register 9 has bit 3 or bit 4 set. While the counter is nonzero, each read of register 11 returns its stored value with bit 5 set and decrements the counter. Otherwise register 11 reads its stored value.
- R9: Any write to the status port (port 2) has three effects: status bit 0 (INT) is cleared, bits 6:4 of register 24 are cleared, and `irq` falls. In the next cycle `irq_clr` is 1 for one cycle.
- R10: A write to register 24 with its old bit 4 at 1 and new bit 4 at 0 clears INT. In the next cycle `irq_clr` is 1 for one cycle. Otherwise the byte is stored in full.
- R11: A `play_irq` pulse sets INT and bit 4 of register 24. If it arrives in the same cycle as a clear from R9 or R10, the set wins, although `irq_clr` still pulses. `irq` equals INT.
- R12: The status port reads {7'b0, INT}. The programmed-I/O port reads 0x00, and writes to it change nothing.
- R13: Every other indirect register stores a written byte in full. `cfg_pin` shows register 10, and `cfg_count` shows {register 14, register 15}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Direct port select: 0 index, 1 data, 2 status, 3 programmed-I/O |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_rd | input | 1 | Read strobe for one byte (needed for the calibration side effect) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port, valid in the same cycle |
| play_irq | input | 1 | One-cycle interrupt request from the playback engine |
| irq | output | 1 | Interrupt line (status INT) |
| irq_clr | output | 1 | One-cycle strobe after an interrupt acknowledge |
| mce | output | 1 | Mode-change-enable flag |
| mode_ext | output | 1 | Extended 32-register mode |
| cfg_format | output | 8 | Rate and format register (8) |
| cfg_iface | output | 8 | Interface configuration register (9) |
| cfg_pin | output | 8 | Pin control register (10) |
| cfg_count | output | 16 | Playback base count {reg 14, reg 15} |

## Verification
The collision that matters is a playback interrupt request in the same cycle as a software acknowledge. The acknowledge can be a status-port write or a register-24 write that clears bit 4. The bench first drives `play_irq` on its own. It then drives `play_irq` together with each kind of acknowledge. A behavioural model, in which set wins and the clear strobe still fires, gives the expected `irq`, `irq_clr` and register-24 readback, and these are compared every cycle. A second overlap is also exercised: the index write that raises mode-change-enable loads the calibration counter, and reads of register 11 consume it. The expected bit 5 follows the counter state in the model.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

    localparam int IDX_W = 5;
    localparam int NREG  = 1 << IDX_W;

    localparam logic [IDX_W-1:0] R_FORMAT = 5'd8;
    localparam logic [IDX_W-1:0] R_IFACE  = 5'd9;
    localparam logic [IDX_W-1:0] R_PIN    = 5'd10;
    localparam logic [IDX_W-1:0] R_ERRST  = 5'd11;
    localparam logic [IDX_W-1:0] R_MODE   = 5'd12;
    localparam logic [IDX_W-1:0] R_CNT_HI = 5'd14;
    localparam logic [IDX_W-1:0] R_CNT_LO = 5'd15;
    localparam logic [IDX_W-1:0] R_RSV_A  = 5'd21;
    localparam logic [IDX_W-1:0] R_ALTST  = 5'd24;
    localparam logic [IDX_W-1:0] R_RSV_B  = 5'd27;
    localparam logic [IDX_W-1:0] R_RSV_C  = 5'd29;

    typedef enum logic [1:0] {
        P_INDEX = 2'd0,
        P_DATA  = 2'd1,
        P_STAT  = 2'd2,
        P_PIO   = 2'd3
    } port_e;

    typedef struct packed {
        logic [NREG-1:0][7:0] ireg;
        logic [6:0]           idx;
        logic                 intr;
        logic                 clr;
    } rf_state_t;

    function automatic logic [7:0] reset_byte(input int n);
        case (n)
            2, 3, 4, 5, 18, 19: reset_byte = 8'h88;
            6, 7:               reset_byte = 8'h80;
            9:                  reset_byte = 8'h08;
            12:                 reset_byte = 8'h8A;
            25, 26:             reset_byte = 8'hA0;
            default:            reset_byte = 8'h00;
        endcase
    endfunction

    function automatic rf_state_t reset_state();
        rf_state_t s;
        for (int n = 0; n < NREG; n++) begin
            s.ireg[n] = reset_byte(n);
        end
        s.idx  = 7'h40;
        s.intr = 1'b0;
        s.clr  = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/codec_idx_dec.sv
module codec_idx_dec #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx_raw,
    input  logic             mode_ext,
    output logic [IDX_W-1:0] idx_eff
);
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        if (b < IDX_W - 1) begin : g_base
            assign idx_eff[b] = idx_raw[b];
        end else begin : g_ext
            assign idx_eff[b] = idx_raw[b] & mode_ext;
        end
    end
endmodule

// File: rtl/codec_cal_ctr.sv
module codec_cal_ctr #(
    parameter int              CAL_W      = 4,
    parameter logic [CAL_W-1:0] CAL_PRESET = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic consume,
    output logic busy
);
    logic [CAL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CAL_PRESET;
        end else if (consume && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
    import codec_regs_pkg::*;
#(
    parameter int              CAL_W      = 4,
    parameter logic [CAL_W-1:0] CAL_PRESET = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        play_irq,
    output logic        irq,
    output logic        irq_clr,
    output logic        mce,
    output logic        mode_ext,
    output logic [7:0]  cfg_format,
    output logic [7:0]  cfg_iface,
    output logic [7:0]  cfg_pin,
    output logic [15:0] cfg_count
);
    rf_state_t s_d, s_q;

    logic [IDX_W-1:0] eff_idx;
    logic             cal_busy;
    logic             cal_load;
    logic             cal_take;
    logic             wr_index, wr_data, wr_stat, rd_data;

    assign wr_index = bus_wr && (bus_addr == P_INDEX);
    assign wr_data  = bus_wr && (bus_addr == P_DATA);
    assign wr_stat  = bus_wr && (bus_addr == P_STAT);
    assign rd_data  = bus_rd && (bus_addr == P_DATA);

    codec_idx_dec #(.IDX_W(IDX_W)) u_dec (
        .idx_raw  (s_q.idx[IDX_W-1:0]),
        .mode_ext (s_q.ireg[R_MODE][6]),
        .idx_eff  (eff_idx)
    );

    assign cal_load = wr_index && !s_q.idx[6] && bus_wdata[6]
                      && (s_q.ireg[R_IFACE][3] || s_q.ireg[R_IFACE][4]);
    assign cal_take = rd_data && (eff_idx == R_ERRST);

    codec_cal_ctr #(.CAL_W(CAL_W), .CAL_PRESET(CAL_PRESET)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cal_load),
        .consume (cal_take),
        .busy    (cal_busy)
    );

    always_comb begin
        s_d     = s_q;
        s_d.clr = 1'b0;

        if (wr_index) begin
            s_d.idx = bus_wdata[6:0];
        end

        if (wr_data) begin
            case (eff_idx)
                R_RSV_A, R_RSV_B, R_RSV_C, R_ERRST: begin
                end
                R_FORMAT: begin
                    if (s_q.idx[6]) begin
                        s_d.ireg[R_FORMAT] = bus_wdata;
                    end else if (s_q.ireg[R_ALTST][4]) begin
                        s_d.ireg[R_FORMAT] = {bus_wdata[7:4], s_q.ireg[R_FORMAT][3:0]};
                    end
                end
                R_IFACE: s_d.ireg[R_IFACE] = bus_wdata & 8'hDF;
                R_MODE: s_d.ireg[R_MODE][6] = bus_wdata[6];
                R_ALTST: begin
                    if (s_q.ireg[R_ALTST][4] && !bus_wdata[4]) begin
                        s_d.intr = 1'b0;
                        s_d.clr  = 1'b1;
                    end
                    s_d.ireg[R_ALTST] = bus_wdata;
                end
                default: s_d.ireg[eff_idx] = bus_wdata;
            endcase
        end

        if (wr_stat) begin
            s_d.intr              = 1'b0;
            s_d.ireg[R_ALTST][6:4] = 3'b000;
            s_d.clr               = 1'b1;
        end

        if (play_irq) begin
            s_d.intr            = 1'b1;
            s_d.ireg[R_ALTST][4] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    always_comb begin
        case (bus_addr)
            P_INDEX: bus_rdata = {1'b0, s_q.idx};
            P_DATA: begin
                bus_rdata = s_q.ireg[eff_idx];
                if (eff_idx == R_ERRST && cal_busy) begin
                    bus_rdata[5] = 1'b1;
                end
            end
            P_STAT:  bus_rdata = {7'b0, s_q.intr};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq        = s_q.intr;
    assign irq_clr    = s_q.clr;
    assign mce        = s_q.idx[6];
    assign mode_ext   = s_q.ireg[R_MODE][6];
    assign cfg_format = s_q.ireg[R_FORMAT];
    assign cfg_iface  = s_q.ireg[R_IFACE];
    assign cfg_pin    = s_q.ireg[R_PIN];
    assign cfg_count  = {s_q.ireg[R_CNT_HI], s_q.ireg[R_CNT_LO]};
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       play_irq,
    input logic       irq,
    input logic       irq_clr,
    input logic       mce,
    input logic [7:0] cfg_format,
    input logic [7:0] cfg_iface
);
    // R2
    index_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |-> (bus_rdata[7] == 1'b0));

    // R6
    iface_bit5_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_iface[5] == 1'b0);

    // R7
    format_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mce |=> $stable(cfg_format[3:0]));

    // R9
    stat_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !play_irq) |=> (!irq && irq_clr));

    // R11
    irq_fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> irq_clr);

    // R11
    play_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        play_irq |=> irq);

    // R12
    stat_read_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd2) |-> (bus_rdata[7:1] == 7'd0 && bus_rdata[0] == irq));
endmodule

bind codec_regfile codec_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .play_irq   (play_irq),
    .irq        (irq),
    .irq_clr    (irq_clr),
    .mce        (mce),
    .cfg_format (cfg_format),
    .cfg_iface  (cfg_iface)
);

// File: tb/codec_regfile_tb.sv
`timescale 1ns/1ps
module codec_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        play_irq = 1'b0;
    logic        irq, irq_clr, mce, mode_ext;
    logic [7:0]  cfg_format, cfg_iface, cfg_pin;
    logic [15:0] cfg_count;

    always #2 clk = ~clk;

    codec_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .play_irq(play_irq), .irq(irq), .irq_clr(irq_clr), .mce(mce),
        .mode_ext(mode_ext), .cfg_format(cfg_format), .cfg_iface(cfg_iface),
        .cfg_pin(cfg_pin), .cfg_count(cfg_count)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference model
    int m_reg [32];
    int m_idx;
    int m_int;
    int m_cal;
    int m_clr;

    function automatic int m_sel();
        if ((m_reg[12] & 'h40) != 0) return m_idx & 31;
        return m_idx & 15;
    endfunction

    function automatic int m_read(input int port);
        int v;
        case (port)
            0: v = m_idx & 'h7F;
            1: begin
                v = m_reg[m_sel()];
                if (m_sel() == 11 && m_cal > 0) v = v | 'h20;
            end
            2: v = m_int;
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic m_reset();
        for (int n = 0; n < 32; n++) m_reg[n] = 0;
        for (int n = 2; n <= 5; n++) m_reg[n] = 'h88;
        m_reg[6] = 'h80; m_reg[7] = 'h80; m_reg[9] = 'h08; m_reg[12] = 'h8A;
        m_reg[18] = 'h88; m_reg[19] = 'h88; m_reg[25] = 'hA0; m_reg[26] = 'hA0;
        m_idx = 'h40; m_int = 0; m_cal = 0; m_clr = 0;
    endtask

    task automatic m_step(input int port, input bit wr, input bit rd, input int wd, input bit pl);
        int sel = m_sel();
        int clr = 0;
        if (rd && port == 1 && sel == 11 && m_cal > 0) m_cal = m_cal - 1;
        if (wr && port == 0) begin
            if ((m_idx & 'h40) == 0 && (wd & 'h40) != 0 && (m_reg[9] & 'h18) != 0) m_cal = 1;
            m_idx = wd & 'h7F;
        end
        if (wr && port == 1) begin
            if (sel == 8) begin
                if ((m_idx & 'h40) != 0 && !(port == 0)) m_reg[8] = wd;
                else if ((m_reg[24] & 'h10) != 0) m_reg[8] = (wd & 'hF0) | (m_reg[8] & 'h0F);
            end else if (sel == 9) m_reg[9] = wd & 'hDF;
            else if (sel == 12) m_reg[12] = (m_reg[12] & 'hBF) | (wd & 'h40);
            else if (sel == 24) begin
                if ((m_reg[24] & 'h10) != 0 && (wd & 'h10) == 0) begin m_int = 0; clr = 1; end
                m_reg[24] = wd;
            end else if (sel != 11 && sel != 21 && sel != 27 && sel != 29) m_reg[sel] = wd;
        end
        if (wr && port == 2) begin
            m_int = 0; m_reg[24] = m_reg[24] & 'h8F; clr = 1;
        end
        if (pl) begin m_int = 1; m_reg[24] = m_reg[24] | 'h10; end
        m_clr = clr;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check("R11 irq", irq, m_int);
        check("R9 irq_clr", irq_clr, m_clr);
        check("R2 mce", mce, (m_idx >> 6) & 1);
        check("R4 mode_ext", mode_ext, (m_reg[12] >> 6) & 1);
        check("R7 cfg_format", cfg_format, m_reg[8]);
        check("R6 cfg_iface", cfg_iface, m_reg[9]);
        check("R13 cfg_pin", cfg_pin, m_reg[10]);
        check("R13 cfg_count", cfg_count, (m_reg[14] << 8) | m_reg[15]);
    endtask

    task automatic cyc(input int port, input bit wr, input bit rd, input int wd,
                       input bit pl, input string tag);
        @(negedge clk);
        bus_addr = port[1:0]; bus_wr = wr; bus_rd = rd; bus_wdata = wd[7:0]; play_irq = pl;
        #1;
        if (rd) check(tag, bus_rdata, m_read(port));
        m_step(port, wr, rd, wd, pl);
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; play_irq = 0;
        compare_outputs();
    endtask

    task automatic wp(input int port, input int v);
        cyc(port, 1, 0, v, 0, "wr");
    endtask
    task automatic rp(input int port, input string tag);
        cyc(port, 0, 1, 0, 0, tag);
    endtask
    task automatic wi(input int ix, input int v);
        wp(0, ix); wp(1, v);
    endtask
    task automatic ri(input int ix, input string tag);
        wp(0, ix); rp(1, tag);
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1; compare_outputs();

        // R1 reset values, basic mode (index keeps MCE set, no counter load)
        rp(0, "R1 index reset");
        rp(2, "R1 status reset");
        for (int n = 0; n < 16; n++) ri('h40 | n, "R1 basic bank reset");

        // R2 bit 7 dropped, MCE clears
        wp(0, 'h89);
        rp(0, "R2 index readback");

        // R6 bit 5 forced low
        wp(1, 'hFF);
        rp(1, "R6 iface readback");

        // R8 counter load on MCE rise with reg9 bits set
        wp(0, 'h4B);
        rp(1, "R8 busy read");
        rp(1, "R8 after consume");
        wp(0, 'h0B); wp(0, 'h4B);
        rp(1, "R8 reload busy");
        rp(1, "R8 reload consumed");
        wi('h09, 'h00);
        wp(0, 'h0B); wp(0, 'h4B);
        rp(1, "R8 no load when reg9 idle");

        // R7 full write under MCE
        wi('h48, 'h5A);
        rp(1, "R7 full write");
        wi('h08, 'h3C);
        rp(1, "R7 dropped without MCE");

        // R4 extended mode, only bit 6 writable
        wi('h0C, 'hFF);
        rp(1, "R4 mode reg");
        for (int n = 16; n < 32; n++) ri(n, "R1 extended bank reset");

        // R7 nibble write path via reg24 bit4
        wi('h18, 'h10);
        rp(1, "R13 reg24 store");
        wi('h08, 'h3C);
        rp(1, "R7 upper nibble only");
        wi('h18, 'h00);
        rp(1, "R10 reg24 cleared");
        wi('h08, 'hE7);
        rp(1, "R7 dropped again");

        // R3 decode width
        wi('h1F, 'h77);
        wi('h0F, 'h11);
        wi('h0E, 'hC3);
        wi('h0A, 'h5E);
        ri('h1F, "R3 extended select");
        wi('h0C, 'h00);
        ri('h1F, "R3 basic aliases to 15");
        wi('h0C, 'h40);

        // R5 discarded writes
        wi('h15, 'hFF); rp(1, "R5 reg21");
        wi('h1B, 'hFF); rp(1, "R5 reg27");
        wi('h1D, 'hFF); rp(1, "R5 reg29");
        wi('h0B, 'hFF); rp(1, "R5 reg11 read-only");

        // R11 playback interrupt, R9 acknowledge
        cyc(0, 0, 0, 0, 1, "R11 play");
        rp(2, "R11 status INT");
        ri('h18, "R11 reg24 PI");
        wi('h18, 'h70);
        wp(2, 'h00);
        rp(2, "R9 status cleared");
        rp(1, "R9 reg24 bits cleared");

        // R11 set wins over simultaneous status acknowledge
        cyc(2, 1, 0, 0, 1, "R11 collide stat");
        rp(2, "R11 INT after collision");
        // R10 PI 1->0 acknowledge
        wi('h18, 'h00);
        rp(2, "R10 INT cleared");
        // R11 set wins over simultaneous reg24 acknowledge
        cyc(0, 0, 0, 0, 1, "R11 play again");
        cyc(1, 1, 0, 'h00, 1, "R11 collide reg24");
        rp(1, "R11 reg24 after collision");
        rp(2, "R11 INT held");
        wp(2, 0);

        // R12 PIO port
        wp(3, 'hA5);
        rp(3, "R12 PIO reads zero");
        rp(2, "R12 status after PIO");
        ri('h18, "R12 reg24 untouched");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule